// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a small 32-bit processor core and performs the entry step into an exception or interrupt handler. When the core strobes `take_i`, the block looks at what is pending: a synchronous exception code, an external interrupt request with its priority level and vector code, or both. It decides whether anything is accepted. If something is accepted, it commits the whole architectural entry on that one clock edge. The entry saves the status word, program counter and stack register, raises the privilege, block and bank bits, and records the event code. It also picks the handler address.

The core supplies its current status word, PC, stack register and vector base on every evaluation, along with the two delay-slot flags. The block returns the updated status word, the three saved-state words, the two event-code words, the new PC and a one-cycle `taken_o` strobe. A separate `sleep_i` pulse records that the core has halted, so that a wake-up interrupt can still get through while exceptions are blocked.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception and an interrupt are both pending at a `take_i` evaluation, the exception is taken and `intevt_o` keeps its old value.
- R2: With the block bit (status bit 28) set, an exception whose code is not 0x1E0 is taken as code 0x000 with the reset handling of R7. Code 0x1E0 is taken unchanged.
- R3: With the block bit set, an interrupt is ignored unless a `sleep_i` pulse has armed the halt marker since the last evaluation. Any accepted evaluation with the block bit set disarms the marker.
- R4: An interrupt is accepted only if its level is strictly greater than status bits 7:4. A rejected request changes no output, and `taken_o` stays low.
- R5: On entry, `ssr_o` gets the old status word, `spc_o` the PC and `sgr_o` the stack register. `sr_o` is the old status word with bits 28 (block), 29 (bank) and 30 (privileged) set.
- R6: If either delay-slot flag is set, the saved PC is the PC minus 2, and `dslot_clr_o` pulses together with `taken_o`.
- R7: Exception codes 0x000, 0x020 and 0x140 clear status bit 15, set status bits 7:4 to 0xF, and jump to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 jump to VBR+0x400. Every other exception jumps to VBR+0x100.
- R9: Exception code 0x160 adds 2 to the saved PC, after any delay-slot correction.
- R10: An exception writes its code to `expevt_o`. An accepted interrupt writes its vector code to `intevt_o` and jumps to VBR+0x600.
- R11: All outputs update on the clock edge at which `take_i` is high, and `taken_o` is high only in the cycle after an accepted evaluation. Without `take_i`, nothing changes.
- R12: After reset, `taken_o` is 0, `expevt_o` and `intevt_o` are 0, `sr_o` is 0x50000000 (block and privileged set) and `pc_o` is 0xA0000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_i | input | 1 | Evaluate pending events this cycle |
| sleep_i | input | 1 | Core has halted; arms the halt marker |
| exc_pend_i | input | 1 | An exception is pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_req_i | input | 1 | An interrupt is requested |
| irq_lvl_i | input | 4 | Requested interrupt level |
| irq_code_i | input | 12 | Interrupt vector code |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| r15_i | input | 32 | Current stack register |
| vbr_i | input | 32 | Vector base |
| dslot_i | input | 1 | Instruction is in an unconditional delay slot |
| dslot_cond_i | input | 1 | Instruction is in a conditional delay slot |
| taken_o | output | 1 | One-cycle strobe: an entry was committed |
| sr_o | output | 32 | Updated status word |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack register |
| pc_o | output | 32 | Handler address |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt vector code |
| dslot_clr_o | output | 1 | Delay-slot flags must be cleared |

## Verification
The bench drives each vector class, including trap, TLB miss, the reset class and the default class. A design that mis-decodes a class would send the core to the wrong handler or leave the mask and FPU bits wrong. It combines the trap code with a delay slot to check that the two corrections to the saved PC cancel each other. It also checks that a level equal to the mask is rejected, since an off-by-one comparison would let that request in. Under the block bit, it checks the reset redirect, the single exempt code, and the halt marker: the marker must let exactly one interrupt through and must not stay armed. A design that kept the marker armed would accept the second request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int SR_FD    = 15;
  localparam int SR_BL    = 28;
  localparam int SR_RB    = 29;
  localparam int SR_MD    = 30;
  localparam int SR_IM_LO = 4;

  localparam logic [11:0] EV_POWERON    = 12'h000;
  localparam logic [11:0] EV_MANUAL     = 12'h020;
  localparam logic [11:0] EV_TLB_MULTI  = 12'h140;
  localparam logic [11:0] EV_TLB_MISS_L = 12'h040;
  localparam logic [11:0] EV_TLB_MISS_S = 12'h060;
  localparam logic [11:0] EV_TRAP       = 12'h160;
  localparam logic [11:0] EV_BL_PASS    = 12'h1E0;

  typedef enum logic [1:0] {PICK_NONE, PICK_EXC, PICK_IRQ} pick_e;
  typedef enum logic [1:0] {VEC_RESET, VEC_TLB, VEC_GENERAL, VEC_IRQ} vec_e;

  function automatic vec_e classify(input logic [11:0] code);
    vec_e v;
    case (code)
      EV_POWERON, EV_MANUAL, EV_TLB_MULTI: v = VEC_RESET;
      EV_TLB_MISS_L, EV_TLB_MISS_S:        v = VEC_TLB;
      default:                             v = VEC_GENERAL;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int LVL_W  = 4
) (
  input  logic              exc_pend,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [LVL_W-1:0]  irq_lvl,
  input  logic [LVL_W-1:0]  imask,
  input  logic              blocked,
  input  logic              halt_mark,
  output pick_e             pick,
  output logic [CODE_W-1:0] eff_code,
  output logic              clear_mark
);

  localparam logic [CODE_W-1:0] PASS_CODE  = CODE_W'(EV_BL_PASS);
  localparam logic [CODE_W-1:0] RESET_CODE = CODE_W'(EV_POWERON);

  always_comb begin
    pick       = PICK_NONE;
    eff_code   = exc_code;
    clear_mark = 1'b0;
    if (exc_pend) begin
      pick       = PICK_EXC;
      clear_mark = blocked;
      if (blocked && exc_code != PASS_CODE) eff_code = RESET_CODE;
    end else if (irq_req) begin
      if (!blocked || halt_mark) begin
        clear_mark = blocked;
        if (irq_lvl > imask) pick = PICK_IRQ;
      end
    end
  end

endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          CODE_W     = 12,
  parameter int          LVL_W      = 4,
  parameter logic [31:0] RESET_PC   = 32'hA000_0000,
  parameter logic [31:0] OFF_GEN    = 32'h0000_0100,
  parameter logic [31:0] OFF_TLB    = 32'h0000_0400,
  parameter logic [31:0] OFF_IRQ    = 32'h0000_0600,
  parameter int          INSN_BYTES = 2
) (
  input  pick_e             pick,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   sr,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   vbr,
  input  logic              in_slot,
  output logic [XLEN-1:0]   sr_n,
  output logic [XLEN-1:0]   spc_n,
  output logic [XLEN-1:0]   pc_n
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
  localparam logic [CODE_W-1:0] TRAP_CODE = CODE_W'(EV_TRAP);

  vec_e vec;
  logic is_trap;

  always_comb begin
    if (pick == PICK_IRQ) vec = VEC_IRQ;
    else                  vec = classify(12'(code));
    is_trap = (pick == PICK_EXC) && (code == TRAP_CODE);
  end

  always_comb begin
    sr_n        = sr;
    sr_n[SR_BL] = 1'b1;
    sr_n[SR_RB] = 1'b1;
    sr_n[SR_MD] = 1'b1;
    if (vec == VEC_RESET) begin
      sr_n[SR_FD]              = 1'b0;
      sr_n[SR_IM_LO +: LVL_W]  = '1;
    end
  end

  always_comb begin
    spc_n = pc;
    if (in_slot) spc_n = spc_n - STEP;
    if (is_trap) spc_n = spc_n + STEP;
  end

  always_comb begin
    case (vec)
      VEC_RESET: pc_n = XLEN'(RESET_PC);
      VEC_TLB:   pc_n = vbr + XLEN'(OFF_TLB);
      VEC_IRQ:   pc_n = vbr + XLEN'(OFF_IRQ);
      default:   pc_n = vbr + XLEN'(OFF_GEN);
    endcase
  end

endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_entry_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CODE_W   = 12,
  parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              sleep,
  input  pick_e             pick,
  input  logic              clear_mark,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [XLEN-1:0]   sr_old,
  input  logic [XLEN-1:0]   r15,
  input  logic [XLEN-1:0]   sr_n,
  input  logic [XLEN-1:0]   spc_n,
  input  logic [XLEN-1:0]   pc_n,
  input  logic              in_slot,
  output logic              halt_mark,
  output logic              taken,
  output logic [XLEN-1:0]   sr_q,
  output logic [XLEN-1:0]   ssr_q,
  output logic [XLEN-1:0]   spc_q,
  output logic [XLEN-1:0]   sgr_q,
  output logic [XLEN-1:0]   pc_q,
  output logic [CODE_W-1:0] expevt_q,
  output logic [CODE_W-1:0] intevt_q,
  output logic              dslot_clr
);

  logic commit;
  logic [XLEN-1:0] sr_rst;

  always_comb begin
    commit        = take && (pick != PICK_NONE);
    sr_rst        = '0;
    sr_rst[SR_BL] = 1'b1;
    sr_rst[SR_MD] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_mark <= 1'b0;
    end else if (sleep) begin
      halt_mark <= 1'b1;
    end else if (take && clear_mark) begin
      halt_mark <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken     <= 1'b0;
      dslot_clr <= 1'b0;
      sr_q      <= sr_rst;
      ssr_q     <= '0;
      spc_q     <= '0;
      sgr_q     <= '0;
      pc_q      <= XLEN'(RESET_PC);
      expevt_q  <= '0;
      intevt_q  <= '0;
    end else begin
      taken     <= commit;
      dslot_clr <= commit && in_slot;
      if (commit) begin
        sr_q  <= sr_n;
        ssr_q <= sr_old;
        spc_q <= spc_n;
        sgr_q <= r15;
        pc_q  <= pc_n;
        if (pick == PICK_EXC) expevt_q <= exc_code;
        else                  intevt_q <= irq_code;
      end
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          CODE_W     = 12,
  parameter int          LVL_W      = 4,
  parameter logic [31:0] RESET_PC   = 32'hA000_0000,
  parameter logic [31:0] OFF_GEN    = 32'h0000_0100,
  parameter logic [31:0] OFF_TLB    = 32'h0000_0400,
  parameter logic [31:0] OFF_IRQ    = 32'h0000_0600,
  parameter int          INSN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic              sleep_i,
  input  logic              exc_pend_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic [LVL_W-1:0]  irq_lvl_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              dslot_i,
  input  logic              dslot_cond_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic              dslot_clr_o
);

  pick_e             pick;
  logic [CODE_W-1:0] eff_code;
  logic              clear_mark;
  logic              halt_mark;
  logic              in_slot;
  logic [XLEN-1:0]   sr_n, spc_n, pc_n;

  assign in_slot = dslot_i | dslot_cond_i;

  exc_arbiter #(.CODE_W(CODE_W), .LVL_W(LVL_W)) u_arb (
    .exc_pend   (exc_pend_i),
    .exc_code   (exc_code_i),
    .irq_req    (irq_req_i),
    .irq_lvl    (irq_lvl_i),
    .imask      (sr_i[SR_IM_LO +: LVL_W]),
    .blocked    (sr_i[SR_BL]),
    .halt_mark  (halt_mark),
    .pick       (pick),
    .eff_code   (eff_code),
    .clear_mark (clear_mark)
  );

  exc_target #(
    .XLEN(XLEN), .CODE_W(CODE_W), .LVL_W(LVL_W), .RESET_PC(RESET_PC),
    .OFF_GEN(OFF_GEN), .OFF_TLB(OFF_TLB), .OFF_IRQ(OFF_IRQ),
    .INSN_BYTES(INSN_BYTES)
  ) u_tgt (
    .pick    (pick),
    .code    (eff_code),
    .sr      (sr_i),
    .pc      (pc_i),
    .vbr     (vbr_i),
    .in_slot (in_slot),
    .sr_n    (sr_n),
    .spc_n   (spc_n),
    .pc_n    (pc_n)
  );

  exc_state #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_PC(RESET_PC)) u_st (
    .clk        (clk),
    .rst        (rst),
    .take       (take_i),
    .sleep      (sleep_i),
    .pick       (pick),
    .clear_mark (clear_mark),
    .exc_code   (eff_code),
    .irq_code   (irq_code_i),
    .sr_old     (sr_i),
    .r15        (r15_i),
    .sr_n       (sr_n),
    .spc_n      (spc_n),
    .pc_n       (pc_n),
    .in_slot    (in_slot),
    .halt_mark  (halt_mark),
    .taken      (taken_o),
    .sr_q       (sr_o),
    .ssr_q      (ssr_o),
    .spc_q      (spc_o),
    .sgr_q      (sgr_o),
    .pc_q       (pc_o),
    .expevt_q   (expevt_o),
    .intevt_q   (intevt_o),
    .dslot_clr  (dslot_clr_o)
  );

  // Entry strobe and commit timing
  assert_taken_follows_take_R11: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> $past(take_i));
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !taken_o |-> ($stable(pc_o) && $stable(sr_o) && $stable(expevt_o) && $stable(intevt_o)));

  // Saved state
  assert_saved_sr_R5: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (ssr_o == $past(sr_i) && sgr_o == $past(r15_i)));
  assert_entry_bits_R5: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (sr_o[SR_BL] && sr_o[SR_RB] && sr_o[SR_MD]));

  // Exception priority leaves the interrupt code alone
  assert_exc_wins_R1: assert property (@(posedge clk) disable iff (rst)
    (taken_o && $past(exc_pend_i)) |-> $stable(intevt_o));

  // Block bit redirect
  assert_blocked_redirect_R2: assert property (@(posedge clk) disable iff (rst)
    (taken_o && $past(exc_pend_i) && $past(sr_i[SR_BL]))
      |-> (expevt_o == '0 || expevt_o == CODE_W'(EV_BL_PASS)));

  // Interrupt level against mask
  assert_level_above_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (taken_o && !$past(exc_pend_i)) |-> ($past(irq_lvl_i) > $past(sr_i[SR_IM_LO +: LVL_W])));

  // Delay slot clear strobe
  assert_slot_clear_R6: assert property (@(posedge clk) disable iff (rst)
    dslot_clr_o |-> (taken_o && $past(dslot_i || dslot_cond_i)));

  // Interrupt handler address
  assert_irq_vector_R10: assert property (@(posedge clk) disable iff (rst)
    (taken_o && !$past(exc_pend_i)) |-> (pc_o == $past(vbr_i) + XLEN'(OFF_IRQ)));

endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        take_i = 0, sleep_i = 0, exc_pend_i = 0, irq_req_i = 0;
  logic [11:0] exc_code_i = 0, irq_code_i = 0;
  logic [3:0]  irq_lvl_i = 0;
  logic [31:0] sr_i = 0, pc_i = 0, r15_i = 0, vbr_i = 32'h8C00_0000;
  logic        dslot_i = 0, dslot_cond_i = 0;
  logic        taken_o, dslot_clr_o;
  logic [31:0] sr_o, ssr_o, spc_o, sgr_o, pc_o;
  logic [11:0] expevt_o, intevt_o;

  always #5 clk = ~clk;

  exc_entry_seq u0 (
    .clk(clk), .rst(rst), .take_i(take_i), .sleep_i(sleep_i),
    .exc_pend_i(exc_pend_i), .exc_code_i(exc_code_i),
    .irq_req_i(irq_req_i), .irq_lvl_i(irq_lvl_i), .irq_code_i(irq_code_i),
    .sr_i(sr_i), .pc_i(pc_i), .r15_i(r15_i), .vbr_i(vbr_i),
    .dslot_i(dslot_i), .dslot_cond_i(dslot_cond_i),
    .taken_o(taken_o), .sr_o(sr_o), .ssr_o(ssr_o), .spc_o(spc_o),
    .sgr_o(sgr_o), .pc_o(pc_o), .expevt_o(expevt_o), .intevt_o(intevt_o),
    .dslot_clr_o(dslot_clr_o)
  );

  typedef struct {
    logic        tk, dc;
    logic [31:0] sr, ssr, spc, sgr, pc;
    logic [11:0] ev, iev;
    string       req;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0;
  bit   armed = 0, done = 0;

  // model state
  logic [31:0] m_sr = 32'h5000_0000, m_ssr = 0, m_spc = 0, m_sgr = 0, m_pc = 32'hA000_0000;
  logic [11:0] m_ev = 0, m_iev = 0;
  bit          m_halt = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic compare(input exp_t e);
    chk(e.req, "taken",   32'(taken_o), 32'(e.tk));
    chk(e.req, "dslot_clr", 32'(dslot_clr_o), 32'(e.dc));
    chk(e.req, "sr",      sr_o,  e.sr);
    chk(e.req, "ssr",     ssr_o, e.ssr);
    chk(e.req, "spc",     spc_o, e.spc);
    chk(e.req, "sgr",     sgr_o, e.sgr);
    chk(e.req, "pc",      pc_o,  e.pc);
    chk(e.req, "expevt",  32'(expevt_o), 32'(e.ev));
    chk(e.req, "intevt",  32'(intevt_o), 32'(e.iev));
  endtask

  // monitor: one evaluation per armed edge
  initial begin
    forever begin
      @(posedge clk);
      if (armed) begin
        @(negedge clk);
        if (q.size() == 0) begin
          total++; bad++;
          $display("FAIL R11 scoreboard empty actual=1 expected=0");
        end else compare(q.pop_front());
      end
    end
  end

  task automatic drive(input bit tk, input bit ep, input logic [11:0] ec,
                       input bit ir, input logic [3:0] lv, input logic [11:0] ic,
                       input logic [31:0] sr, input logic [31:0] pc,
                       input bit ds, input bit dsc, input string req);
    exp_t e;
    bit go_exc, go_irq, bl;
    logic [11:0] code;
    logic [31:0] r15;
    r15 = pc ^ 32'h0000_55AA;
    @(negedge clk);
    take_i = tk; exc_pend_i = ep; exc_code_i = ec; irq_req_i = ir;
    irq_lvl_i = lv; irq_code_i = ic; sr_i = sr; pc_i = pc; r15_i = r15;
    dslot_i = ds; dslot_cond_i = dsc; armed = 1;
    go_exc = 0; go_irq = 0; bl = sr[28]; code = ec;
    if (tk) begin
      if (ep) begin
        go_exc = 1;
        if (bl && ec != 12'h1E0) code = 12'h000;
        if (bl) m_halt = 0;
      end else if (ir) begin
        if (!bl || m_halt) begin
          if (bl) m_halt = 0;
          if (lv > sr[7:4]) go_irq = 1;
        end
      end
    end
    e.tk = go_exc || go_irq;
    e.dc = e.tk && (ds || dsc);
    if (e.tk) begin
      m_ssr = sr; m_sgr = r15;
      m_spc = (ds || dsc) ? pc - 2 : pc;
      m_sr = sr | 32'h7000_0000;
      if (go_exc) begin
        m_ev = code;
        if (code == 12'h000 || code == 12'h020 || code == 12'h140) begin
          m_sr[15] = 1'b0; m_sr[7:4] = 4'hF; m_pc = 32'hA000_0000;
        end else if (code == 12'h040 || code == 12'h060) begin
          m_pc = vbr_i + 32'h400;
        end else begin
          if (code == 12'h160) m_spc = m_spc + 2;
          m_pc = vbr_i + 32'h100;
        end
      end else begin
        m_iev = ic; m_pc = vbr_i + 32'h600;
      end
    end
    e.sr = m_sr; e.ssr = m_ssr; e.spc = m_spc; e.sgr = m_sgr; e.pc = m_pc;
    e.ev = m_ev; e.iev = m_iev; e.req = req;
    q.push_back(e);
    @(negedge clk);
    take_i = 0; exc_pend_i = 0; irq_req_i = 0; dslot_i = 0; dslot_cond_i = 0; armed = 0;
  endtask

  task automatic sleep_pulse();
    @(negedge clk); sleep_i = 1;
    @(negedge clk); sleep_i = 0; m_halt = 1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "taken", 32'(taken_o), 0);
    chk("R12", "sr", sr_o, 32'h5000_0000);
    chk("R12", "expevt", 32'(expevt_o), 0);
    chk("R12", "intevt", 32'(intevt_o), 0);
    chk("R12", "pc", pc_o, 32'hA000_0000);

    // R5 R8 R10: general exception
    drive(1, 1, 12'h180, 0, 0, 0, 32'h0000_0030, 32'h0000_1000, 0, 0, "R5_R8_R10");
    // R8 TLB miss codes
    drive(1, 1, 12'h040, 0, 0, 0, 32'h0000_0000, 32'h0000_2000, 0, 0, "R8");
    drive(1, 1, 12'h060, 0, 0, 0, 32'h0000_0010, 32'h0000_2004, 0, 0, "R8");
    // R7 reset class with FD set and low mask
    drive(1, 1, 12'h140, 0, 0, 0, 32'h0000_8030, 32'h0000_3000, 0, 0, "R7");
    drive(1, 1, 12'h020, 0, 0, 0, 32'h0000_8000, 32'h0000_3010, 0, 0, "R7");
    // R9 trap, plain and in a delay slot
    drive(1, 1, 12'h160, 0, 0, 0, 32'h0000_0000, 32'h0000_4000, 0, 0, "R9");
    drive(1, 1, 12'h160, 0, 0, 0, 32'h0000_0000, 32'h0000_4100, 0, 1, "R9_R6");
    // R6 delay slot on general exception
    drive(1, 1, 12'h180, 0, 0, 0, 32'h0000_0000, 32'h0000_5000, 1, 0, "R6");
    // R10 interrupt accepted (level 5 > mask 3)
    drive(1, 0, 0, 1, 4'd5, 12'h320, 32'h0000_0030, 32'h0000_6000, 0, 0, "R10_R4");
    // R1 both pending: exception wins, intevt kept
    drive(1, 1, 12'h0E0, 1, 4'd9, 12'h3A0, 32'h0000_0000, 32'h0000_7000, 0, 0, "R1");
    // R4 level equal to mask: rejected, nothing changes
    drive(1, 0, 0, 1, 4'd3, 12'h340, 32'h0000_0030, 32'h0000_7100, 0, 0, "R4");
    drive(1, 0, 0, 1, 4'd0, 12'h360, 32'h0000_0000, 32'h0000_7200, 0, 0, "R4");
    // R2 block bit: redirect to reset, exempt code kept
    drive(1, 1, 12'h180, 0, 0, 0, 32'h1000_0000, 32'h0000_8000, 0, 0, "R2");
    drive(1, 1, 12'h1E0, 0, 0, 0, 32'h1000_0000, 32'h0000_8100, 0, 0, "R2");
    // R3 block bit: ignored, wake after sleep once, ignored again
    drive(1, 0, 0, 1, 4'd8, 12'h400, 32'h1000_0000, 32'h0000_9000, 0, 0, "R3");
    sleep_pulse();
    drive(1, 0, 0, 1, 4'd8, 12'h420, 32'h1000_0000, 32'h0000_9100, 0, 0, "R3");
    drive(1, 0, 0, 1, 4'd8, 12'h440, 32'h1000_0000, 32'h0000_9200, 0, 0, "R3");
    // R3 marker disarmed even when the woken request is masked by level
    sleep_pulse();
    drive(1, 0, 0, 1, 4'd2, 12'h460, 32'h1000_0050, 32'h0000_9300, 0, 0, "R3");
    drive(1, 0, 0, 1, 4'd9, 12'h480, 32'h1000_0050, 32'h0000_9400, 0, 0, "R3");
    // R11 no take: pending events ignored
    drive(0, 1, 12'h180, 1, 4'd15, 12'h500, 32'h0000_0000, 32'h0000_A000, 1, 0, "R11");
    drive(1, 0, 0, 0, 0, 0, 32'h0000_0000, 32'h0000_A100, 0, 0, "R11");
    // R11 a later accepted entry still commits normally
    drive(1, 0, 0, 1, 4'd12, 12'h520, 32'h0000_00A0, 32'h0000_B000, 0, 1, "R11_R6");
    repeat (2) @(negedge clk);
    summary();
  end

endmodule